// File: doc/BRIEF.md
# Bunch Crossing Orbit Monitor

This block follows the orbit timing of one incoming link. It keeps a bunch-crossing counter that restarts on every orbit marker the link delivers, and it watches for markers that come too soon or too late, for valid words whose BX0 bit disagrees with the low bit of the counter, and for bunch crossings read from an empty alignment FIFO. Each kind of fault has its own small saturating error counter. The four counters and the underflow-report enable are packed into a 16-bit status word.

A three-state machine drives the bunch counter. `ARMED` is entered on power-up and on resync. Here the counter sits at its preset and waits for the first marker, which moves it to `COUNTING` without raising an error. In `COUNTING` the counter steps once per clock. A marker at the last count of the orbit is the expected case. A marker before that point is an early marker. Reaching the end of the orbit with no marker moves the machine to `HOLD`. In `HOLD` the counter stays at the preset until a marker arrives, which counts as a late marker and returns the machine to `COUNTING`. A resync from any state returns the machine to `ARMED`. Only the underflow counter can raise the out-of-sync flag, and it does so only when reporting is enabled.

Top module: `bx_orbit_monitor`

## Requirements
- R1: After power-up reset, and one clock after `resync_i`, `bx_cnt_o` equals 3564 (the orbit length). At reset all error counters and `oos_o` are 0.
- R2: A clock with `marker_i` high sets `bx_cnt_o` to 0 on the next edge. Without a marker the count then rises by one each clock.
- R3: When `bx_cnt_o` is 3563 and no marker is present, the count goes to 3564. It stays at 3564 until a marker arrives. It never exceeds 3564.
- R4: A marker seen while `bx_cnt_o` is below 3563 (after the first marker) increments the early counter, `status_o[7:4]`.
- R5: A marker seen while the count is held at 3564 after an orbit increments the late counter, `status_o[11:8]`. The first marker after reset or resync is counted as neither early nor late. A marker at count 3563 raises no error.
- R6: A clock with `valid_i` high and `bx0_i` different from bit 0 of `bx_cnt_o` increments the mismatch counter, `status_o[3:0]`. If the two bits match, the counter is unchanged.
- R7: Each clock with `rd_empty_i` high increments the underflow counter, `status_o[14:12]`. That counter saturates at 7.
- R8: The 4-bit early, late and mismatch counters saturate at 15.
- R9: `soft_rst_i`, `clr_i` and `resync_i` each clear all error counters on the next edge, and take priority over any increment in the same clock. `soft_rst_i` and `clr_i` leave the bunch counter running.
- R10: `oos_o` is high exactly when `uf_en_i` is high and the underflow counter is nonzero.
- R11: `status_o` is packed as {`uf_en_i`, underflow[2:0], late[3:0], early[3:0], mismatch[3:0]}, from bit 15 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| marker_i | input | 1 | Orbit marker from the link |
| valid_i | input | 1 | Link word valid |
| bx0_i | input | 1 | BX0 bit of the link word |
| rd_empty_i | input | 1 | A bunch crossing was read from an empty alignment FIFO |
| resync_i | input | 1 | Resync command |
| soft_rst_i | input | 1 | Soft reset of the error counters |
| clr_i | input | 1 | Per-link error counter clear |
| uf_en_i | input | 1 | Underflow-report enable |
| bx_cnt_o | output | 12 | Bunch-crossing counter |
| status_o | output | 16 | Packed enable and error counters |
| oos_o | output | 1 | Out-of-sync flag |

## Verification
The late-marker case is the hardest condition to reach from the ports. The machine has to be in `HOLD`, which needs a full orbit of 3564 clocks after a real marker. A count of 3564 alone is not enough, because the same value in `ARMED` must not count as late. The stimulus therefore sends a first marker, lets the counter run until the port reads 3563, steps past the end of the orbit, and holds there for a few clocks before sending the marker. After a later resync, the bench checks that the next marker leaves the late counter at zero.

// File: rtl/bxmon_pkg.sv
package bxmon_pkg;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_COUNTING = 2'd1,
        ST_HOLD     = 2'd2
    } orbit_state_t;

    localparam int EV_MIS   = 0;
    localparam int EV_EARLY = 1;
    localparam int EV_LATE  = 2;
    localparam int EV_UF    = 3;
    localparam int NUM_EV   = 4;

endpackage

// File: rtl/bxmon_sat_cnt.sv
module bxmon_sat_cnt #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] q_o
);
    localparam logic [WIDTH-1:0] MAX_VAL = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (clr_i) begin
            q_o <= '0;
        end else if (inc_i && q_o != MAX_VAL) begin
            q_o <= q_o + 1'b1;
        end
    end
endmodule

// File: rtl/bxmon_orbit_fsm.sv
module bxmon_orbit_fsm
    import bxmon_pkg::*;
#(
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = $clog2(ORBIT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             marker_i,
    input  logic             resync_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             early_o,
    output logic             late_o
);
    localparam logic [CNT_W-1:0] PRESET   = CNT_W'(ORBIT_LEN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ORBIT_LEN - 1);

    orbit_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            cnt_q   <= PRESET;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state, counter and event outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        early_o = 1'b0;
        late_o  = 1'b0;
        if (resync_i) begin
            state_d = ST_ARMED;
            cnt_d   = PRESET;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (marker_i) begin
                        state_d = ST_COUNTING;
                        cnt_d   = '0;
                    end
                end
                ST_COUNTING: begin
                    if (marker_i) begin
                        cnt_d   = '0;
                        early_o = (cnt_q != LAST_CNT);
                    end else if (cnt_q == LAST_CNT) begin
                        state_d = ST_HOLD;
                        cnt_d   = PRESET;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (marker_i) begin
                        state_d = ST_COUNTING;
                        cnt_d   = '0;
                        late_o  = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_ARMED;
                    cnt_d   = PRESET;
                end
            endcase
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/bx_orbit_monitor.sv
module bx_orbit_monitor
    import bxmon_pkg::*;
#(
    parameter int ORBIT_LEN = 3564,
    parameter int ERR_W     = 4,
    parameter int UF_W      = 3,
    parameter int CNT_W     = $clog2(ORBIT_LEN + 1),
    parameter int STAT_W    = 1 + UF_W + 3 * ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              marker_i,
    input  logic              valid_i,
    input  logic              bx0_i,
    input  logic              rd_empty_i,
    input  logic              resync_i,
    input  logic              soft_rst_i,
    input  logic              clr_i,
    input  logic              uf_en_i,
    output logic [CNT_W-1:0]  bx_cnt_o,
    output logic [STAT_W-1:0] status_o,
    output logic              oos_o
);
    localparam int MAX_W = (ERR_W > UF_W) ? ERR_W : UF_W;

    logic              early_evt, late_evt, clr_any;
    logic [NUM_EV-1:0] ev;
    logic [MAX_W-1:0]  err_q [NUM_EV];

    bxmon_orbit_fsm #(
        .ORBIT_LEN (ORBIT_LEN),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .marker_i (marker_i),
        .resync_i (resync_i),
        .cnt_o    (bx_cnt_o),
        .early_o  (early_evt),
        .late_o   (late_evt)
    );

    assign clr_any       = soft_rst_i | clr_i | resync_i;
    assign ev[EV_MIS]    = valid_i & (bx0_i ^ bx_cnt_o[0]);
    assign ev[EV_EARLY]  = early_evt;
    assign ev[EV_LATE]   = late_evt;
    assign ev[EV_UF]     = rd_empty_i;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_err
        localparam int W = (i == EV_UF) ? UF_W : ERR_W;
        bxmon_sat_cnt #(.WIDTH(W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_any),
            .inc_i (ev[i]),
            .q_o   (err_q[i][W-1:0])
        );
        if (W < MAX_W) begin : g_pad
            assign err_q[i][MAX_W-1:W] = '0;
        end
    end

    assign status_o = {uf_en_i,
                       err_q[EV_UF][UF_W-1:0],
                       err_q[EV_LATE][ERR_W-1:0],
                       err_q[EV_EARLY][ERR_W-1:0],
                       err_q[EV_MIS][ERR_W-1:0]};

    assign oos_o = uf_en_i & (|err_q[EV_UF][UF_W-1:0]);
endmodule

// File: rtl/bxmon_checker.sv
module bxmon_checker #(
    parameter int ORBIT_LEN = 3564,
    parameter int ERR_W     = 4,
    parameter int UF_W      = 3,
    parameter int CNT_W     = $clog2(ORBIT_LEN + 1),
    parameter int STAT_W    = 1 + UF_W + 3 * ERR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              marker_i,
    input logic              resync_i,
    input logic              soft_rst_i,
    input logic              clr_i,
    input logic              uf_en_i,
    input logic [CNT_W-1:0]  bx_cnt_o,
    input logic [STAT_W-1:0] status_o,
    input logic              oos_o
);
    localparam logic [CNT_W-1:0] PRESET   = CNT_W'(ORBIT_LEN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ORBIT_LEN - 1);
    localparam logic [ERR_W-1:0] ERR_MAX  = '1;
    localparam logic [UF_W-1:0]  UF_MAX   = '1;

    logic             clr_any;
    logic [ERR_W-1:0] mis_q, early_q;
    logic [UF_W-1:0]  uf_q;

    assign clr_any = soft_rst_i | clr_i | resync_i;
    assign mis_q   = status_o[ERR_W-1:0];
    assign early_q = status_o[2*ERR_W-1:ERR_W];
    assign uf_q    = status_o[STAT_W-2 -: UF_W];

    AST_PRESET_ON_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        resync_i |=> bx_cnt_o == PRESET); // R1
    AST_MARKER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (marker_i && !resync_i) |=> bx_cnt_o == '0); // R2
    AST_HOLD_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_cnt_o == PRESET && !marker_i && !resync_i) |=> bx_cnt_o == PRESET); // R3
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bx_cnt_o <= PRESET); // R3
    AST_EARLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (marker_i && !clr_any && bx_cnt_o < LAST_CNT && early_q != ERR_MAX)
        |=> early_q == $past(early_q) + 1'b1); // R4
    AST_UF_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q == UF_MAX && !clr_any) |=> uf_q == UF_MAX); // R7
    AST_MIS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_q == ERR_MAX && !clr_any) |=> mis_q == ERR_MAX); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> status_o[STAT_W-2:0] == '0); // R9
    AST_OOS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_en_i |-> !oos_o); // R10
endmodule

bind bx_orbit_monitor bxmon_checker #(
    .ORBIT_LEN (ORBIT_LEN),
    .ERR_W     (ERR_W),
    .UF_W      (UF_W),
    .CNT_W     (CNT_W),
    .STAT_W    (STAT_W)
) u_bxmon_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .marker_i   (marker_i),
    .resync_i   (resync_i),
    .soft_rst_i (soft_rst_i),
    .clr_i      (clr_i),
    .uf_en_i    (uf_en_i),
    .bx_cnt_o   (bx_cnt_o),
    .status_o   (status_o),
    .oos_o      (oos_o)
);

// File: tb/test_bx_orbit_monitor.sv
`timescale 1ns/1ps
module test_bx_orbit_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        marker_i = 0, valid_i = 0, bx0_i = 0, rd_empty_i = 0;
    logic        resync_i = 0, soft_rst_i = 0, clr_i = 0, uf_en_i = 0;
    logic [11:0] bx_cnt_o;
    logic [15:0] status_o;
    logic        oos_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    bx_orbit_monitor i_bx_orbit_monitor (
        .clk(clk), .rst_n(rst_n), .marker_i(marker_i), .valid_i(valid_i),
        .bx0_i(bx0_i), .rd_empty_i(rd_empty_i), .resync_i(resync_i),
        .soft_rst_i(soft_rst_i), .clr_i(clr_i), .uf_en_i(uf_en_i),
        .bx_cnt_o(bx_cnt_o), .status_o(status_o), .oos_o(oos_o)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
    endtask

    task automatic run_to(int target);
        for (int k = 0; k < 4000 && int'(bx_cnt_o) != target; k++) tick();
    endtask

    task automatic pulse_marker();
        marker_i = 1; tick(); marker_i = 0;
    endtask

    task automatic t_reset();
        check("R1 preset after reset", bx_cnt_o, 3564);
        check("R1 errors zero after reset", status_o, 0);
        check("R1 oos low after reset", oos_o, 0);
    endtask

    task automatic t_first_marker();
        pulse_marker();
        check("R2 marker restarts count", bx_cnt_o, 0);
        check("R5 first marker not late", status_o[11:8], 0);
        check("R5 first marker not early", status_o[7:4], 0);
        for (int k = 0; k < 5; k++) tick();
        check("R2 count advances", bx_cnt_o, 5);
    endtask

    task automatic t_mismatch();
        valid_i = 1; bx0_i = bx_cnt_o[0]; tick();
        check("R6 matching BX0 no count", status_o[3:0], 0);
        bx0_i = ~bx_cnt_o[0]; tick();
        check("R6 mismatch counts", status_o[3:0], 1);
        for (int k = 0; k < 20; k++) begin bx0_i = ~bx_cnt_o[0]; tick(); end
        valid_i = 0; bx0_i = 0;
        check("R8 mismatch saturates", status_o[3:0], 15);
    endtask

    task automatic t_normal_orbit();
        run_to(3563);
        check("R2 reached last count", bx_cnt_o, 3563);
        pulse_marker();
        check("R5 on-time marker restarts", bx_cnt_o, 0);
        check("R5 on-time marker no early", status_o[7:4], 0);
        check("R5 on-time marker no late", status_o[11:8], 0);
    endtask

    task automatic t_early();
        run_to(100);
        pulse_marker();
        check("R4 early marker counted", status_o[7:4], 1);
        check("R4 early marker restarts", bx_cnt_o, 0);
    endtask

    task automatic t_late();
        run_to(3563);
        tick();
        check("R3 advances to 3564", bx_cnt_o, 3564);
        for (int k = 0; k < 3; k++) tick();
        check("R3 holds at 3564", bx_cnt_o, 3564);
        pulse_marker();
        check("R5 late marker counted", status_o[11:8], 1);
        check("R5 late marker restarts", bx_cnt_o, 0);
    endtask

    task automatic t_underflow();
        uf_en_i = 0; rd_empty_i = 1;
        tick();
        check("R7 underflow counts", status_o[14:12], 1);
        check("R10 oos masked", oos_o, 0);
        for (int k = 0; k < 9; k++) tick();
        rd_empty_i = 0;
        check("R7 underflow saturates", status_o[14:12], 7);
        check("R10 oos masked at 7", oos_o, 0);
        uf_en_i = 1; #1;
        check("R10 oos raised", oos_o, 1);
        check("R11 packing", status_o, {1'b1, 3'd7, 4'd1, 4'd1, 4'd15});
    endtask

    task automatic t_clear();
        int c;
        c = bx_cnt_o;
        clr_i = 1; rd_empty_i = 1; tick(); clr_i = 0; rd_empty_i = 0;
        check("R9 clear wins", status_o[14:0], 0);
        check("R9 clear keeps counter", bx_cnt_o, c + 1);
        check("R10 oos low after clear", oos_o, 0);
        rd_empty_i = 1; tick(); tick(); rd_empty_i = 0;
        check("R7 underflow after clear", status_o[14:12], 2);
        c = bx_cnt_o;
        soft_rst_i = 1; tick(); soft_rst_i = 0;
        check("R9 soft reset clears", status_o[14:0], 0);
        check("R9 soft reset keeps counter", bx_cnt_o, c + 1);
        rd_empty_i = 1; tick(); rd_empty_i = 0;
        resync_i = 1; tick(); resync_i = 0;
        check("R1 resync presets", bx_cnt_o, 3564);
        check("R9 resync clears", status_o[14:0], 0);
        for (int k = 0; k < 4; k++) tick();
        pulse_marker();
        check("R5 first marker after resync not late", status_o[11:8], 0);
        check("R2 restart after resync", bx_cnt_o, 0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_first_marker();
        t_mismatch();
        t_normal_orbit();
        t_early();
        t_late();
        t_underflow();
        t_clear();
        done = 1;
    end

    initial begin
        for (int k = 0; k < 200000 && !done; k++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule